// File: doc/BRIEF.md
# Rank-Batching DRAM Read Scheduler

This block chooses the next command for a DRAM channel that carries several ranks. Read requests arrive on a valid/ready stream. Each request names a rank, a bank, a row and a column. Requests wait in a small age-ordered queue. Every cycle the block places at most one command on its command slot: a row activate, a column read, a precharge, or nothing. Row activates are decoupled from column reads. A bank can therefore be opened for a request long before that request reaches the front of the queue, which spreads activates out ahead of the reads that need them.

The block does not keep any timers. Per-bank ready flags come from outside and are used as given: activate-legal (this flag also carries the activate-rate limit), read-legal and precharge-legal. The block does track which row is open in each bank, using the activates and precharges it issues itself.

Column reads stay on one rank for as long as that rank has reads ready, up to a batch limit. When reads move to a different rank, a programmable number of idle read slots must pass first, so the data bursts of the two ranks do not collide. A mode pin selects plain first-come-first-served operation, in which only the oldest request may drive any command. This mode serves as the baseline with no reordering.

Stream rules: a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on the queue fill level. It is low whenever the queue is full, even on a cycle where a read retires an entry. A sender may hold `req_valid` high with stable fields for as long as it needs to.

Top module: `rank_batch_sched`

## Requirements
- R1: `req_ready` is high exactly when fewer than DEPTH requests are queued. A request is stored on each cycle where `req_valid` and `req_ready` are both high.
- R2: The command slot carries one command per cycle, encoded as 0 for none, 1 for activate, 2 for read and 3 for precharge. Rank, bank, row and column are those of the chosen request, and all of them are zero when the command is none. With an empty queue the command is none.
- R3: A read is issued only for a request whose bank is open on the request's row and whose read-legal flag is high. The request leaves the queue in the cycle its read is issued.
- R4: Two requests to the same rank and bank are never reordered. Only the oldest queued request of each bank may cause an activate, a read or a precharge.
- R5: When no read can issue, the block activates for the oldest bank-front request whose bank is closed and whose activate-legal flag is high. That request need not be the oldest in the queue. An activate opens the bank on the request's row.
- R6: When neither a read nor an activate can issue, the block precharges for the oldest bank-front request whose bank holds a different open row and whose precharge-legal flag is high. A precharge closes the bank.
- R7: Among reads that can issue, the block picks the oldest read in the rank of the previous read. The rank of the previous read is 0 after reset.
- R8: After MAX_BATCH consecutive reads to one rank, that rank issues no further reads while another rank has a read ready.
- R9: A read to a rank other than the previous read's rank issues only after at least SWITCH_GAP cycles without any read since the previous read.
- R10: With `fcfs_mode` high, only the oldest queued request may cause a command, and the batch limit does not apply. The read, activate and precharge conditions and the rank gap still apply.
- R11: After reset the queue is empty, all banks are closed, the command is none and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 selects oldest-first operation with no reordering |
| req_valid | input | 1 | Request on the input stream is valid |
| req_ready | output | 1 | Queue can take a request |
| req_rank | input | $clog2(NR) | Request rank |
| req_bank | input | $clog2(NB) | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| act_ok | input | NR*NB | Per-bank activate legal, indexed rank*NB+bank |
| rd_ok | input | NR*NB | Per-bank column read legal |
| pre_ok | input | NR*NB | Per-bank precharge legal |
| cmd_kind | output | 2 | 0 none, 1 activate, 2 read, 3 precharge |
| cmd_rank | output | $clog2(NR) | Command rank |
| cmd_bank | output | $clog2(NB) | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |

## Verification
The bench builds the block with two ranks, two banks per rank, a queue depth of six, a batch limit of three and a rank gap of two cycles. The queue is shallow, so it fills often, which exercises the back-pressure rule. The short batch limit makes rank yields frequent, and the two-cycle gap produces cycles where a ready read in the other rank has to wait. Requests use only three rows, which gives a steady mix of row hits and row conflicts, so activates go to requests that are not at the front of the queue and precharges happen regularly.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/rbs_queue.sv
module rbs_queue #(
  parameter int DEPTH = 8,
  parameter int EW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [EW-1:0]             push_ent,
  input  logic                      pop,
  input  logic [IW-1:0]             pop_idx,
  output logic [CW-1:0]             count,
  output logic [DEPTH-1:0]          ent_vld,
  output logic [DEPTH-1:0][EW-1:0]  ent
);
  logic [DEPTH-1:0][EW-1:0] mem, mem_n;
  logic [CW-1:0] cnt, cnt_n, base;

  always_comb begin
    mem_n = mem;
    base  = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= pop_idx) mem_n[i] = mem[i+1];
      end
      base = cnt - CW'(1);
    end
    if (push) mem_n[IW'(base)] = push_ent;
    cnt_n = cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mem <= '0;
    end else begin
      cnt <= cnt_n;
      mem <= mem_n;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_vld[i] = (CW'(i) < cnt);
  end

  assign count = cnt;
  assign ent   = mem;

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CW'(DEPTH)));

  // R3
  pop_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CW'(pop_idx) < cnt));
endmodule

// File: rtl/rbs_bank_table.sv
module rbs_bank_table
  import rbs_pkg::*;
#(
  parameter int NR    = 2,
  parameter int NB    = 4,
  parameter int ROW_W = 8,
  localparam int NBK  = NR * NB,
  localparam int FBW  = $clog2(NR) + $clog2(NB)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  cmd_kind_e                   kind,
  input  logic [FBW-1:0]              fb,
  input  logic [ROW_W-1:0]            row,
  output logic [NBK-1:0]              open_vec,
  output logic [NBK-1:0][ROW_W-1:0]   open_row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vec <= '0;
      open_row <= '0;
    end else if (kind == CMD_ACT) begin
      open_vec[fb] <= 1'b1;
      open_row[fb] <= row;
    end else if (kind == CMD_PRE) begin
      open_vec[fb] <= 1'b0;
    end
  end

  // R5
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_ACT) |-> !open_vec[fb]);

  // R6
  pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_PRE) |-> open_vec[fb]);
endmodule

// File: rtl/rbs_rank_gap.sv
module rbs_rank_gap #(
  parameter int NR         = 2,
  parameter int MAX_BATCH  = 4,
  parameter int SWITCH_GAP = 2,
  localparam int RKW = $clog2(NR),
  localparam int GW  = $clog2(SWITCH_GAP + 1),
  localparam int BCW = $clog2(MAX_BATCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_fire,
  input  logic [RKW-1:0] rd_rank,
  output logic [RKW-1:0] cur_rank,
  output logic           gap_clear,
  output logic           batch_full
);
  logic [GW-1:0]  gap_cnt;
  logic [BCW-1:0] batch_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_rank  <= '0;
      gap_cnt   <= '0;
      batch_cnt <= '0;
    end else if (rd_fire) begin
      cur_rank <= rd_rank;
      gap_cnt  <= GW'(SWITCH_GAP);
      if (rd_rank != cur_rank) batch_cnt <= BCW'(1);
      else if (batch_cnt != BCW'(MAX_BATCH)) batch_cnt <= batch_cnt + BCW'(1);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - GW'(1);
    end
  end

  assign gap_clear  = (gap_cnt == '0);
  assign batch_full = (batch_cnt >= BCW'(MAX_BATCH));

  // R9
  switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (rd_rank != cur_rank)) |-> gap_clear);
endmodule

// File: rtl/rbs_picker.sv
module rbs_picker
  import rbs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NR    = 2,
  parameter int NB    = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int RKW  = $clog2(NR),
  localparam int BKW  = $clog2(NB),
  localparam int FBW  = RKW + BKW,
  localparam int NBK  = NR * NB,
  localparam int EW   = RKW + BKW + ROW_W + COL_W,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0][EW-1:0]    ent,
  input  logic [NBK-1:0]              open_vec,
  input  logic [NBK-1:0][ROW_W-1:0]   open_row,
  input  logic [NBK-1:0]              act_ok,
  input  logic [NBK-1:0]              rd_ok,
  input  logic [NBK-1:0]              pre_ok,
  input  logic                        fcfs,
  input  logic [RKW-1:0]              cur_rank,
  input  logic                        gap_clear,
  input  logic                        batch_full,
  output cmd_kind_e                   kind,
  output logic [RKW-1:0]              out_rank,
  output logic [BKW-1:0]              out_bank,
  output logic [ROW_W-1:0]            out_row,
  output logic [COL_W-1:0]            out_col,
  output logic                        pop,
  output logic [IW-1:0]               pop_idx
);
  logic [DEPTH-1:0][RKW-1:0]   e_rk;
  logic [DEPTH-1:0][BKW-1:0]   e_bk;
  logic [DEPTH-1:0][ROW_W-1:0] e_row;
  logic [DEPTH-1:0][FBW-1:0]   e_fb;
  logic [DEPTH-1:0] head, hit, cons, rdy;
  logic [DEPTH-1:0] c_cur, c_oth, c_act, c_pre, use_cur, use_oth;
  logic yield;
  logic [IW-1:0] sel;

  function automatic logic [IW-1:0] first_idx(input logic [DEPTH-1:0] m);
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (m[i]) first_idx = IW'(i);
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      e_row[i] = ent[i][COL_W +: ROW_W];
      e_bk[i]  = ent[i][COL_W + ROW_W +: BKW];
      e_rk[i]  = ent[i][COL_W + ROW_W + BKW +: RKW];
      e_fb[i]  = {e_rk[i], e_bk[i]};
    end
  end

  // bank-front filter: an entry may act only if no older entry shares its bank
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      head[i] = ent_vld[i];
      for (int j = 0; j < i; j++) begin
        if (ent_vld[j] && (e_fb[j] == e_fb[i])) head[i] = 1'b0;
      end
      hit[i]   = open_vec[e_fb[i]] && (open_row[e_fb[i]] == e_row[i]);
      cons[i]  = !fcfs || (i == 0);
      rdy[i]   = head[i] && cons[i] && hit[i] && rd_ok[e_fb[i]];
      c_cur[i] = rdy[i] && (e_rk[i] == cur_rank);
      c_oth[i] = rdy[i] && (e_rk[i] != cur_rank);
      c_act[i] = head[i] && cons[i] && !open_vec[e_fb[i]] && act_ok[e_fb[i]];
      c_pre[i] = head[i] && cons[i] && open_vec[e_fb[i]] && !hit[i] && pre_ok[e_fb[i]];
    end
  end

  assign yield   = batch_full && (|c_oth) && !fcfs;
  assign use_cur = c_cur & {DEPTH{!yield}};
  assign use_oth = c_oth & {DEPTH{gap_clear}};

  always_comb begin
    kind = CMD_NONE;
    sel  = '0;
    if (|use_cur) begin
      kind = CMD_RD;
      sel  = first_idx(use_cur);
    end else if (|use_oth) begin
      kind = CMD_RD;
      sel  = first_idx(use_oth);
    end else if (|c_act) begin
      kind = CMD_ACT;
      sel  = first_idx(c_act);
    end else if (|c_pre) begin
      kind = CMD_PRE;
      sel  = first_idx(c_pre);
    end
  end

  always_comb begin
    if (kind == CMD_NONE) begin
      out_rank = '0;
      out_bank = '0;
      out_row  = '0;
      out_col  = '0;
    end else begin
      out_rank = e_rk[sel];
      out_bank = e_bk[sel];
      out_row  = e_row[sel];
      out_col  = ent[sel][COL_W-1:0];
    end
  end

  assign pop     = (kind == CMD_RD);
  assign pop_idx = sel;
endmodule

// File: rtl/rank_batch_sched.sv
module rank_batch_sched
  import rbs_pkg::*;
#(
  parameter int NR         = 2,
  parameter int NB         = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int DEPTH      = 8,
  parameter int MAX_BATCH  = 4,
  parameter int SWITCH_GAP = 2,
  localparam int RKW = $clog2(NR),
  localparam int BKW = $clog2(NB),
  localparam int NBK = NR * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcfs_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RKW-1:0]    req_rank,
  input  logic [BKW-1:0]    req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [NBK-1:0]    act_ok,
  input  logic [NBK-1:0]    rd_ok,
  input  logic [NBK-1:0]    pre_ok,
  output logic [1:0]        cmd_kind,
  output logic [RKW-1:0]    cmd_rank,
  output logic [BKW-1:0]    cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  localparam int FBW = RKW + BKW;
  localparam int EW  = RKW + BKW + ROW_W + COL_W;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic                     push, pop;
  logic [IW-1:0]            pop_idx;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0]         ent_vld;
  logic [DEPTH-1:0][EW-1:0] ent;
  logic [NBK-1:0]           open_vec;
  logic [NBK-1:0][ROW_W-1:0] open_row;
  logic [RKW-1:0]           cur_rank;
  logic                     gap_clear, batch_full;
  cmd_kind_e                kind;
  logic [FBW-1:0]           cmd_fb;

  assign req_ready = (count < CW'(DEPTH));
  assign push      = req_valid && req_ready;

  rbs_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_ent({req_rank, req_bank, req_row, req_col}),
    .pop(pop), .pop_idx(pop_idx), .count(count),
    .ent_vld(ent_vld), .ent(ent)
  );

  rbs_picker #(.DEPTH(DEPTH), .NR(NR), .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
    .ent_vld(ent_vld), .ent(ent), .open_vec(open_vec), .open_row(open_row),
    .act_ok(act_ok), .rd_ok(rd_ok), .pre_ok(pre_ok), .fcfs(fcfs_mode),
    .cur_rank(cur_rank), .gap_clear(gap_clear), .batch_full(batch_full),
    .kind(kind), .out_rank(cmd_rank), .out_bank(cmd_bank),
    .out_row(cmd_row), .out_col(cmd_col), .pop(pop), .pop_idx(pop_idx)
  );

  assign cmd_fb = {cmd_rank, cmd_bank};

  rbs_bank_table #(.NR(NR), .NB(NB), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .kind(kind), .fb(cmd_fb), .row(cmd_row),
    .open_vec(open_vec), .open_row(open_row)
  );

  rbs_rank_gap #(.NR(NR), .MAX_BATCH(MAX_BATCH), .SWITCH_GAP(SWITCH_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .rd_fire(pop), .rd_rank(cmd_rank),
    .cur_rank(cur_rank), .gap_clear(gap_clear), .batch_full(batch_full)
  );

  assign cmd_kind = kind;

  // R3
  rd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_RD) |-> (rd_ok[cmd_fb] && open_vec[cmd_fb] && (open_row[cmd_fb] == cmd_row)));

  // R5
  act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_ACT) |-> act_ok[cmd_fb]);

  // R6
  pre_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CMD_PRE) |-> pre_ok[cmd_fb]);

  // R2
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (kind == CMD_NONE));

  // R10
  fcfs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fcfs_mode && pop) |-> (pop_idx == '0));
endmodule

// File: tb/rank_batch_sched_test.sv
module rank_batch_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 2, NB = 2, ROW_W = 3, COL_W = 4;
  localparam int DEPTH = 6, MAX_BATCH = 3, SWITCH_GAP = 2;
  localparam int NBK = NR * NB;
  localparam int RUN_CYCLES = 7000;

  logic clk = 0, rst_n = 0, fcfs_mode = 0, req_valid = 0;
  logic req_ready;
  logic [0:0] req_rank = 0, req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic [NBK-1:0] act_ok = 0, rd_ok = 0, pre_ok = 0;
  logic [1:0] cmd_kind;
  logic [0:0] cmd_rank, cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int mcnt = 0;
  int mr[DEPTH], mb[DEPTH], mrow[DEPTH], mcol[DEPTH];
  int mo[NBK], morow[NBK];
  int mcur = 0, mgap = 0, mbat = 0;
  int cov_full = 0, cov_rdb = 0, cov_sb = 0, cov_ooo = 0, cov_pre = 0;
  int cov_cur = 0, cov_yield = 0, cov_gap = 0, cov_fcfs = 0, cov_sw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_batch_sched #(.NR(NR), .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH),
    .MAX_BATCH(MAX_BATCH), .SWITCH_GAP(SWITCH_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_rank(req_rank), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .act_ok(act_ok), .rd_ok(rd_ok),
    .pre_ok(pre_ok), .cmd_kind(cmd_kind), .cmd_rank(cmd_rank),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int cyc);
    fcfs_mode = (cyc >= 3000 && cyc < 5000);
    req_valid = (cyc >= 5000) ? 1'b1 : ($urandom_range(0, 3) != 0);
    req_rank  = 1'($urandom_range(0, NR - 1));
    req_bank  = 1'($urandom_range(0, NB - 1));
    req_row   = ROW_W'($urandom_range(0, 2));
    req_col   = COL_W'($urandom_range(0, 15));
    for (int k = 0; k < NBK; k++) begin
      act_ok[k] = ($urandom_range(0, 9) < 6);
      rd_ok[k]  = ($urandom_range(0, 9) < 5);
      pre_ok[k] = ($urandom_range(0, 9) < 5);
    end
  endtask

  task automatic step();
    int kind = 0, idx = 0, fb;
    string tag = "R2";
    bit hd[DEPTH], ht[DEPTH], rdy[DEPTH], cr[DEPTH], ot[DEPTH], ac[DEPTH], pr[DEPTH];
    bit any_oth = 0, any_cur = 0, yield, fc, sbf = 0, rbf = 0;
    int er, eb, erow, ecol, exp_rdy;
    fc = fcfs_mode;
    for (int i = 0; i < mcnt; i++) begin
      int f = mr[i] * NB + mb[i];
      bit cons = !fc || (i == 0);
      hd[i] = 1;
      for (int j = 0; j < i; j++) if (mr[j] * NB + mb[j] == f) hd[i] = 0;
      ht[i]  = (mo[f] != 0) && (morow[f] == mrow[i]);
      rdy[i] = hd[i] && cons && ht[i] && rd_ok[f];
      cr[i]  = rdy[i] && (mr[i] == mcur);
      ot[i]  = rdy[i] && (mr[i] != mcur);
      ac[i]  = hd[i] && cons && (mo[f] == 0) && act_ok[f];
      pr[i]  = hd[i] && cons && (mo[f] != 0) && !ht[i] && pre_ok[f];
      if (ot[i]) any_oth = 1;
      if (cr[i]) any_cur = 1;
      if (ht[i] && rd_ok[f] && !hd[i]) sbf = 1;
      if (hd[i] && ht[i] && !rd_ok[f]) rbf = 1;
    end
    if (sbf) cov_sb++;
    if (rbf) cov_rdb++;
    if (mcnt == DEPTH) cov_full++;
    yield = (mbat >= MAX_BATCH) && any_oth && !fc;
    if (yield && any_cur) cov_yield++;
    if (!yield) for (int i = 0; i < mcnt; i++) if (cr[i]) begin
      kind = 2; idx = i; tag = fc ? "R10" : "R7"; break;
    end
    if (kind == 0 && any_oth && mgap != 0) cov_gap++;
    if (kind == 0 && mgap == 0) for (int i = 0; i < mcnt; i++) if (ot[i]) begin
      kind = 2; idx = i; tag = fc ? "R10" : "R9"; break;
    end
    if (kind == 0) for (int i = 0; i < mcnt; i++) if (ac[i]) begin
      kind = 1; idx = i; tag = fc ? "R10" : "R5"; break;
    end
    if (kind == 0) for (int i = 0; i < mcnt; i++) if (pr[i]) begin
      kind = 3; idx = i; tag = fc ? "R10" : "R6"; break;
    end
    if (kind != 0) begin
      er = mr[idx]; eb = mb[idx]; erow = mrow[idx]; ecol = mcol[idx];
    end else begin
      er = 0; eb = 0; erow = 0; ecol = 0;
    end
    check(cmd_kind == 2'(kind), tag, "cmd_kind", cmd_kind, kind);
    check(cmd_rank == 1'(er) && cmd_bank == 1'(eb) && cmd_row == ROW_W'(erow) &&
          cmd_col == COL_W'(ecol), tag, "fields rank*1000+bank*100+row*10+col",
          cmd_rank*1000 + cmd_bank*100 + cmd_row*10 + cmd_col,
          er*1000 + eb*100 + erow*10 + ecol);
    exp_rdy = (mcnt < DEPTH);
    check(req_ready == 1'(exp_rdy), "R1", "req_ready", req_ready, exp_rdy);
    // advance reference state to the next edge
    fb = er * NB + eb;
    if (kind == 1) begin
      mo[fb] = 1; morow[fb] = erow;
      if (!fc && idx > 0) cov_ooo++;
    end else if (kind == 3) begin
      mo[fb] = 0; cov_pre++;
    end
    if (kind == 2) begin
      if (fc) cov_fcfs++;
      else if (er == mcur) cov_cur++;
      else cov_sw++;
      mbat = (er == mcur) ? ((mbat < MAX_BATCH) ? mbat + 1 : mbat) : 1;
      mcur = er;
      mgap = SWITCH_GAP;
      for (int i = idx; i < mcnt - 1; i++) begin
        mr[i] = mr[i+1]; mb[i] = mb[i+1]; mrow[i] = mrow[i+1]; mcol[i] = mcol[i+1];
      end
    end else if (mgap > 0) mgap--;
    if (req_valid && exp_rdy != 0) begin
      int p = (kind == 2) ? mcnt - 1 : mcnt;
      mr[p] = req_rank; mb[p] = req_bank; mrow[p] = req_row; mcol[p] = req_col;
      mcnt = p + 1;
    end else if (kind == 2) mcnt--;
  endtask

  initial begin
    for (int k = 0; k < NBK; k++) begin mo[k] = 0; morow[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state observed at the ports
    check(cmd_kind == 2'd0, "R11", "cmd_kind in reset", cmd_kind, 0);
    check(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check(cmd_kind == 2'd0, "R11", "cmd_kind after reset", cmd_kind, 0);
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(posedge clk); #1;
      drive(cyc);
      @(negedge clk);
      step();
    end
    // scenario reach checks
    check(cov_full > 0, "R1", "cycles with queue full", cov_full, 1);
    check(cov_rdb > 0, "R3", "open-row requests held by read-legal low", cov_rdb, 1);
    check(cov_sb > 0, "R4", "row-hit requests held behind same bank", cov_sb, 1);
    check(cov_ooo > 0, "R5", "activates for non-oldest request", cov_ooo, 1);
    check(cov_pre > 0, "R6", "precharges issued", cov_pre, 1);
    check(cov_cur > 0, "R7", "same-rank reads", cov_cur, 1);
    check(cov_yield > 0, "R8", "batch-limit yields", cov_yield, 1);
    check(cov_gap > 0 && cov_sw > 0, "R9", "gap waits and rank switches", cov_gap, 1);
    check(cov_fcfs > 0, "R10", "oldest-first reads", cov_fcfs, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (RUN_CYCLES * 4) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule